// File: doc/BRIEF.md
# Dual Interval Timer with Interrupt Control

This block holds two 16-bit down counters. Each one has its own reload latch. An auxiliary-control byte picks the timer-1 mode, and a pair of interrupt flag and enable bytes controls a single active-high interrupt line. A host reaches every register through a byte-wide bus. The register index is taken from address bits 12:9. Reads return data combinationally, and writes take effect at the clock edge on which `reg_wr` is high. The counters step once on each clock where `tick_en` is high, so a divider outside the block sets the count rate.

Timer 1 counts from its loaded value down through 0 to 0xFFFF. In continuous mode it then reloads from its latch, which gives a period of latch + 2 ticks. Timer 2 is loaded directly and raises its flag only once for each arming. A flag input from an external shift unit feeds a third interrupt source. Only the shift-unit flag and the timer-1 flag can drive the interrupt line.

Top module: `dual_timer_irq`

## Requirements
- R1: After reset the timer-1 counter and latch both read 0xFFFF, the timer-2 counter reads 0xFFFF, and all flags and enables are 0. The interrupt line is therefore low.
- R2: The register index is taken from `reg_addr` (address bits 12:9). The decoded indices are: 4 = t1 count low, 5 = t1 count high, 6 = t1 latch low, 7 = t1 latch high, 8 = t2 low, 9 = t2 high, 11 = aux control, 13 = flags, 14 = enables. Any other index reads 0x00.
- R3: A counter drops by one on each clock with `tick_en` high, and it holds its value when `tick_en` is low.
- R4: A write to index 4 changes only the t1 latch low byte. A write to index 5 sets the t1 latch high byte and loads the counter from the full latch. Writes to indices 6 and 7 change the latch only and never the counter.
- R5: Aux control bits 7:6 = 01 select continuous mode. In that mode a tick taken at 0xFFFF reloads the counter from the latch. The t1 flag (flag bit 6) is set each time the counter reaches 0, so the flag sets repeat every latch + 2 ticks.
- R6: In any other mode, t1 sets its flag once after an index-5 write. After that it keeps counting down past 0xFFFF without reloading.
- R7: A write to index 8 stores the t2 low latch byte and loads the counter with that byte zero-extended. A write to index 9 loads the counter with {written byte, stored low byte} and arms t2. An armed t2 sets flag bit 5 once, when it reaches 0.
- R8: Reading index 4 clears the t1 flag, and writing index 5 also clears it. Reading index 8 clears the t2 flag, and writing index 9 also clears it. Writing index 13 clears every flag bit that is written as 1. A flag source that fires in the same cycle as a clear wins over the clear.
- R9: A write to index 14 with bit 7 set ORs bits 6:0 into the enables. With bit 7 clear, the write clears the enable bits that are 1 in bits 6:0. Index 14 reads back as {1, enables}.
- R10: `irq` is high exactly when flag and enable are both set on bit 2 or bit 6. Flag bit 5 never drives `irq`. Index 13 reads back as {irq, flags}.
- R11: A high level on `sr_done` sets flag bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Count-enable strobe for both counters |
| reg_addr | input | 4 | Register index (address bits 12:9) |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (for read side effects) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational |
| sr_done | input | 1 | Shift-unit event, sets flag bit 2 |
| irq | output | 1 | Active-high interrupt |

## Verification
Every write, tick and read side effect lands at the next rising edge. Flags register in that same edge, and `irq` and `reg_rdata` follow combinationally from the registers. The results are therefore visible one edge after the stimulus. The bench drives inputs at the falling edge and reads results at the following falling edge, so it never samples at an active edge. Tick bursts are counted edge by edge, which lets the expected counter value and the exact tick on which a flag appears (for example latch + 2 ticks between t1 flags) be computed in advance.

// File: rtl/dti_pkg.sv
package dti_pkg;
  localparam int CNT_W = 16;

  typedef enum logic [3:0] {
    IDX_T1_CNT_LO = 4'd4,
    IDX_T1_CNT_HI = 4'd5,
    IDX_T1_LAT_LO = 4'd6,
    IDX_T1_LAT_HI = 4'd7,
    IDX_T2_LO     = 4'd8,
    IDX_T2_HI     = 4'd9,
    IDX_AUX       = 4'd11,
    IDX_FLAGS     = 4'd13,
    IDX_ENABLES   = 4'd14
  } reg_idx_e;

  localparam int FLG_SR = 2;
  localparam int FLG_T2 = 5;
  localparam int FLG_T1 = 6;
  localparam logic [1:0] T1_MODE_CONT = 2'b01;
endpackage

// File: rtl/dti_counter.sv
module dti_counter #(
  parameter int W = 16,
  parameter bit HAS_RELOAD = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         arm,
  input  logic         periodic,
  input  logic [W-1:0] reload_val,
  output logic [W-1:0] cnt,
  output logic         hit
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] cnt_nx;
  logic         armed, armed_nx;
  logic         do_reload;

  always_comb begin
    do_reload = HAS_RELOAD && periodic && (&cnt);
    cnt_nx    = cnt;
    if (load)           cnt_nx = load_val;
    else if (tick)      cnt_nx = do_reload ? reload_val : cnt - ONE;
    hit = tick && !load && (cnt_nx == '0) && (armed || (HAS_RELOAD && periodic));
    armed_nx = armed;
    if (arm)            armed_nx = 1'b1;
    else if (hit)       armed_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '1;
      armed <= 1'b0;
    end else begin
      cnt   <= cnt_nx;
      armed <= armed_nx;
    end
  end

  // R3: step by one per tick unless a reload is due
  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !load && !(HAS_RELOAD && periodic && (&cnt))) |=> cnt == $past(cnt) - ONE);
  // R3: no tick, no load -> value held
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt));
  // R4/R7: a load wins and takes the load value
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt == $past(load_val));
  // R5: wrap from all-ones reloads in continuous mode
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_RELOAD && tick && !load && periodic && (&cnt)) |=> cnt == $past(reload_val));
endmodule

// File: rtl/dti_irq_ctrl.sv
module dti_irq_ctrl
  import dti_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       set_t1,
  input  logic       set_t2,
  input  logic       set_sr,
  input  logic       clr_t1,
  input  logic       clr_t2,
  input  logic       flags_wr,
  input  logic       en_wr,
  input  logic [7:0] wdata,
  output logic [6:0] flags,
  output logic [6:0] enables,
  output logic       irq
);
  localparam logic [6:0] IRQ_MASK = 7'((1 << FLG_SR) | (1 << FLG_T1));

  logic [6:0] flags_nx, en_nx, set_vec, clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[FLG_T1] = set_t1;
    set_vec[FLG_T2] = set_t2;
    set_vec[FLG_SR] = set_sr;
    clr_vec = flags_wr ? wdata[6:0] : 7'd0;
    clr_vec[FLG_T1] = clr_vec[FLG_T1] | clr_t1;
    clr_vec[FLG_T2] = clr_vec[FLG_T2] | clr_t2;
    flags_nx = (flags & ~clr_vec) | set_vec;
    en_nx = enables;
    if (en_wr) en_nx = wdata[7] ? (enables | wdata[6:0]) : (enables & ~wdata[6:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags   <= '0;
      enables <= '0;
    end else begin
      flags   <= flags_nx;
      enables <= en_nx;
    end
  end

  assign irq = |(flags & enables & IRQ_MASK);

  // R9: set-form write ORs bits in
  p_en_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && wdata[7]) |=> (enables & $past(wdata[6:0])) == $past(wdata[6:0]));
  // R9: clear-form write removes bits
  p_en_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !wdata[7]) |=> (enables & $past(wdata[6:0])) == 7'd0);
  // R11: shift event always lands in the flags
  p_sr_flag_r11: assert property (@(posedge clk) disable iff (!rst_n)
    set_sr |=> flags[FLG_SR]);
  // R10: timer-2 alone never raises the line
  p_t2_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[FLG_SR] == 1'b0 && flags[FLG_T1] == 1'b0) |-> !irq);
endmodule

// File: rtl/dual_timer_irq.sv
module dual_timer_irq
  import dti_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic [12:9] reg_addr,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        sr_done,
  output logic        irq
);
  localparam int HB = CNT_W / 2;

  logic [CNT_W-1:0] t1_latch, t1_latch_nx, t1_cnt, t2_cnt;
  logic [HB-1:0]    t2_lo, t2_lo_nx;
  logic [7:0]       aux, aux_nx;
  logic [6:0]       flags, enables;
  logic             t1_hit, t2_hit;
  logic             wr_t1lo, wr_t1hi, wr_t1llo, wr_t1lhi, wr_t2lo, wr_t2hi;
  logic             wr_aux, wr_flags, wr_en, rd_t1lo, rd_t2lo;
  logic [CNT_W-1:0] t1_load_val, t2_load_val;
  logic             t2_load;
  logic [3:0]       idx;

  assign idx = reg_addr;

  always_comb begin
    wr_t1lo  = reg_wr && idx == IDX_T1_CNT_LO;
    wr_t1hi  = reg_wr && idx == IDX_T1_CNT_HI;
    wr_t1llo = reg_wr && idx == IDX_T1_LAT_LO;
    wr_t1lhi = reg_wr && idx == IDX_T1_LAT_HI;
    wr_t2lo  = reg_wr && idx == IDX_T2_LO;
    wr_t2hi  = reg_wr && idx == IDX_T2_HI;
    wr_aux   = reg_wr && idx == IDX_AUX;
    wr_flags = reg_wr && idx == IDX_FLAGS;
    wr_en    = reg_wr && idx == IDX_ENABLES;
    rd_t1lo  = reg_rd && idx == IDX_T1_CNT_LO;
    rd_t2lo  = reg_rd && idx == IDX_T2_LO;

    t1_latch_nx = t1_latch;
    if (wr_t1lo || wr_t1llo) t1_latch_nx[HB-1:0]     = reg_wdata;
    if (wr_t1hi || wr_t1lhi) t1_latch_nx[CNT_W-1:HB] = reg_wdata;
    t1_load_val = {reg_wdata, t1_latch[HB-1:0]};

    t2_lo_nx = wr_t2lo ? reg_wdata : t2_lo;
    t2_load  = wr_t2lo || wr_t2hi;
    t2_load_val = wr_t2hi ? {reg_wdata, t2_lo} : {{HB{1'b0}}, reg_wdata};

    aux_nx = wr_aux ? reg_wdata : aux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      t1_latch <= '1;
      t2_lo    <= '0;
      aux      <= '0;
    end else begin
      t1_latch <= t1_latch_nx;
      t2_lo    <= t2_lo_nx;
      aux      <= aux_nx;
    end
  end

  dti_counter #(.W(CNT_W), .HAS_RELOAD(1'b1)) u_t1 (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .load(wr_t1hi), .load_val(t1_load_val), .arm(wr_t1hi),
    .periodic(aux[7:6] == T1_MODE_CONT), .reload_val(t1_latch),
    .cnt(t1_cnt), .hit(t1_hit)
  );

  dti_counter #(.W(CNT_W), .HAS_RELOAD(1'b0)) u_t2 (
    .clk(clk), .rst_n(rst_n), .tick(tick_en),
    .load(t2_load), .load_val(t2_load_val), .arm(wr_t2hi),
    .periodic(1'b0), .reload_val('0),
    .cnt(t2_cnt), .hit(t2_hit)
  );

  dti_irq_ctrl u_irq (
    .clk(clk), .rst_n(rst_n),
    .set_t1(t1_hit), .set_t2(t2_hit), .set_sr(sr_done),
    .clr_t1(rd_t1lo || wr_t1hi), .clr_t2(rd_t2lo || wr_t2hi),
    .flags_wr(wr_flags), .en_wr(wr_en), .wdata(reg_wdata),
    .flags(flags), .enables(enables), .irq(irq)
  );

  always_comb begin
    case (idx)
      IDX_T1_CNT_LO: reg_rdata = t1_cnt[HB-1:0];
      IDX_T1_CNT_HI: reg_rdata = t1_cnt[CNT_W-1:HB];
      IDX_T1_LAT_LO: reg_rdata = t1_latch[HB-1:0];
      IDX_T1_LAT_HI: reg_rdata = t1_latch[CNT_W-1:HB];
      IDX_T2_LO:     reg_rdata = t2_cnt[HB-1:0];
      IDX_T2_HI:     reg_rdata = t2_cnt[CNT_W-1:HB];
      IDX_AUX:       reg_rdata = aux;
      IDX_FLAGS:     reg_rdata = {irq, flags};
      IDX_ENABLES:   reg_rdata = {1'b1, enables};
      default:       reg_rdata = 8'h00;
    endcase
  end

  // R4: latch-only writes leave the t1 counter untouched when idle
  p_latch_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_t1llo || wr_t1lhi || wr_t1lo) && !tick_en) |=> $stable(t1_cnt));
  // R8: counter-high write leaves t1 flag clear unless a hit coincides
  p_t1_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_t1hi && !t1_hit) |=> !flags[FLG_T1]);
endmodule

// File: tb/dual_timer_irq_tb.sv
module dual_timer_irq_tb;
  logic       clk, rst_n, tick_en, reg_wr, reg_rd, sr_done;
  logic [3:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq;
  int         total, bad;

  dual_timer_irq u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sr_done(sr_done), .irq(irq)
  );

  initial begin clk = 1'b0; forever #10 clk = ~clk; end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] i, input logic [7:0] d);
    @(negedge clk); reg_addr = i; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] i, output logic [7:0] d, input bit fx = 1'b1);
    @(negedge clk); reg_addr = i; reg_rd = fx; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin @(negedge clk); tick_en = 1'b1; end
    @(negedge clk); tick_en = 1'b0;
  endtask

  task automatic rd16(input logic [3:0] lo, output int v);
    logic [7:0] a, b;
    rd(lo + 4'd1, b); rd(lo, a, 1'b0);
    v = {b, a};
  endtask

  task automatic t_reset;
    int v; logic [7:0] d;
    rd16(4'd4, v); chk("R1 t1 cnt", v, 16'hFFFF);
    rd16(4'd6, v); chk("R1 t1 latch", v, 16'hFFFF);
    rd16(4'd8, v); chk("R1 t2 cnt", v, 16'hFFFF);
    rd(4'd13, d); chk("R1 flags", d, 0);
    rd(4'd2, d);  chk("R2 unused idx", d, 0);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_latch;
    int v;
    wr(4'd6, 8'h34); wr(4'd7, 8'h12);
    rd16(4'd4, v); chk("R4 latch write keeps cnt", v, 16'hFFFF);
    rd16(4'd6, v); chk("R4 latch readback", v, 16'h1234);
    wr(4'd4, 8'h56);
    rd16(4'd6, v); chk("R4 cnt-lo hits latch", v, 16'h1256);
    rd16(4'd4, v); chk("R4 cnt-lo no load", v, 16'hFFFF);
    wr(4'd5, 8'h00);
    rd16(4'd4, v); chk("R4 cnt-hi load", v, 16'h0056);
    ticks(6);
    rd16(4'd4, v); chk("R3 decrement", v, 16'h0050);
    repeat (4) @(negedge clk);
    rd16(4'd4, v); chk("R3 hold", v, 16'h0050);
  endtask

  task automatic t_cont;
    logic [7:0] d; int v;
    wr(4'd11, 8'h40); wr(4'd14, 8'hC0);
    wr(4'd4, 8'h03); wr(4'd5, 8'h00);
    ticks(2); chk("R5 no irq early", irq, 0);
    ticks(1); chk("R5 irq at zero", irq, 1);
    rd(4'd13, d, 1'b0); chk("R10 flags read", d, 8'hC0);
    rd(4'd4, d); chk("R8 read t1 lo", d, 8'h00);
    chk("R8 read clears", irq, 0);
    ticks(1); rd16(4'd4, v); chk("R5 wrap", v, 16'hFFFF);
    ticks(1); rd16(4'd4, v); chk("R5 reload", v, 16'h0003);
    ticks(2); chk("R5 period not yet", irq, 0);
    ticks(1); chk("R5 period latch+2", irq, 1);
    wr(4'd13, 8'h40); chk("R8 flag write clear", irq, 0);
  endtask

  task automatic t_oneshot;
    logic [7:0] d; int v;
    wr(4'd11, 8'h00);
    wr(4'd4, 8'h02); wr(4'd5, 8'h00);
    ticks(2); chk("R6 one-shot fires", irq, 1);
    wr(4'd5, 8'h00); chk("R8 cnt-hi clears", irq, 0);
    ticks(2); wr(4'd13, 8'h40);
    ticks(2); rd16(4'd4, v); chk("R6 no reload", v, 16'hFFFE);
    rd(4'd13, d, 1'b0); chk("R6 no second flag", d[6], 0);
  endtask

  task automatic t_t2;
    logic [7:0] d; int v;
    wr(4'd14, 8'h20);
    wr(4'd8, 8'h05);
    rd16(4'd8, v); chk("R7 low load", v, 16'h0005);
    wr(4'd9, 8'h01);
    rd16(4'd8, v); chk("R7 high load", v, 16'h0105);
    wr(4'd9, 8'h00);
    ticks(5);
    rd(4'd13, d, 1'b0); chk("R7 t2 flag", d[5], 1);
    chk("R10 t2 no irq", irq, 0);
    rd(4'd8, d); rd(4'd13, d, 1'b0); chk("R8 t2 read clears", d[5], 0);
    ticks(3); rd(4'd13, d, 1'b0); chk("R7 once only", d[5], 0);
  endtask

  task automatic t_sr;
    logic [7:0] d;
    wr(4'd14, 8'h7F);
    @(negedge clk); sr_done = 1'b1; @(negedge clk); sr_done = 1'b0;
    rd(4'd13, d, 1'b0); chk("R11 sr flag", d[2], 1);
    chk("R10 sr masked", irq, 0);
    wr(4'd14, 8'h84); chk("R9 set enables", irq, 1);
    rd(4'd14, d); chk("R9 readback", d, 8'h84);
    wr(4'd14, 8'h04); chk("R9 clear enables", irq, 0);
    rd(4'd14, d); chk("R9 cleared", d, 8'h80);
    wr(4'd13, 8'h04); rd(4'd13, d, 1'b0); chk("R8 sr clear", d[2], 0);
  endtask

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; tick_en = 0; reg_wr = 0; reg_rd = 0; sr_done = 0;
    reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset; t_latch; t_cont; t_oneshot; t_t2; t_sr;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2000000;
    total++; bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule